// File: doc/BRIEF.md
# Latch-or-Register Bus Driver

The block carries a parameterised data word (16 bits by default) from an input bus to an output bus. It works in one of two modes, chosen by a single mode input. In flow mode the output follows the input word. In hold mode the stored word changes only when a capture strobe rises. A separate active-high disable input takes the whole output bus off the line. The stored word is left alone while the bus is disabled.

The implementation is fully synchronous to a fast system clock. The capture strobe, the mode input and the disable input are treated as asynchronous. Each passes through a two-flop synchronizer. A rising capture strobe is found by comparing the synchronized sample with the one registered a cycle before. The output is an enable-qualified pair: a data vector and a per-bit drive enable. A pad ring or a tristate wrapper turns the pair into a real three-state bus.

Top module: `bdrv_core`

## Requirements
- R1: While `out_dis` is 1, every bit of `y_en` is 0, whatever `hold_mode`, `cap_clk` and `a_in` do.
- R2: While `hold_mode` is 0 (flow mode), `y_data` equals the `a_in` value sampled at the previous system clock edge.
- R3: While `hold_mode` is 1, a 0-to-1 transition of `cap_clk` loads the current `a_in` word into the store, and that word appears on `y_data`.
- R4: While `hold_mode` is 1 and `cap_clk` stays at 0, stays at 1, or falls, `y_data` keeps its stored value.
- R5: When `hold_mode` goes from 0 to 1 with no capture edge, the last word seen in flow mode is held. No capture edge is needed for this.
- R6: Setting `out_dis` to 1 and back to 0 leaves the stored word unchanged. After re-enabling, `y_data` shows the retained word.
- R7: An active-low `rst_n` clears the stored word to 0 and all of `y_en` to 0. `y_en` stays 0 after reset until `out_dis` is sampled low.
- R8: All bit positions share the same controls. `y_en` is always all zeros or all ones.
- R9: Latencies:
  - A change of `out_dis`, or a rising `cap_clk`, shows on the outputs at the third system clock rising edge after the change.
  - In flow mode, a change of `a_in` shows on `y_data` after the first rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the control inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | W | Input data word |
| out_dis | input | 1 | Output disable, active high, asynchronous |
| hold_mode | input | 1 | 0 = flow mode, 1 = hold mode; asynchronous |
| cap_clk | input | 1 | Capture strobe; its rising edge loads the word in hold mode |
| y_data | output | W | Output data word (stored value) |
| y_en | output | W | Per-bit drive enable; 1 = bit driven |

## Verification
Results fall due at fixed times after each stimulus:
- A flow-mode data change shows one system clock edge later.
- A change on the disable or capture inputs shows three edges later. The synchronizer takes two edges and the output register one.

The bench drives all inputs on the falling system clock edge. In its directed latency checks it samples on the falling edges just before and just after the due edge. In random stepping it holds each input set for four cycles before comparing, so every result has settled. The checker ties its windows to the same counts through `$past` depths of one and three.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;

  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_HOLD = 1'b1
  } mode_e;

  // Decide whether the store loads the input word this cycle.
  function automatic logic take_word(input mode_e mode, input logic cap_rise);
    return (mode == MODE_FLOW) || cap_rise;
  endfunction

  // Drive enable for one bit from the synchronized disable level.
  function automatic logic drive_of(input logic dis_level);
    return ~dis_level;
  endfunction

endpackage

// File: rtl/bdrv_sync.sv
module bdrv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[LAST];
endmodule

// File: rtl/bdrv_rise_det.sv
module bdrv_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign rise = level & ~prev;
endmodule

// File: rtl/bdrv_store_bit.sv
module bdrv_store_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (take) q <= d;
  end
endmodule

// File: rtl/bdrv_drive.sv
module bdrv_drive import bdrv_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dis_level,
  output logic [W-1:0] en
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= drive_of(dis_level);
  end

  generate
    for (genvar b = 0; b < W; b++) begin : g_fan
      assign en[b] = en_q;
    end
  endgenerate
endmodule

// File: rtl/bdrv_core.sv
module bdrv_core import bdrv_pkg::*; #(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         out_dis,
  input  logic         hold_mode,
  input  logic         cap_clk,
  output logic [W-1:0] y_data,
  output logic [W-1:0] y_en
);
  // Named internal events, brought out for the checker.
  logic  dis_s;
  logic  le_s;
  logic  cap_s;
  logic  cap_rise;
  logic  take;
  mode_e mode;

  bdrv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dis (
    .clk(clk), .rst_n(rst_n), .d_async(out_dis), .q_sync(dis_s)
  );

  bdrv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mode (
    .clk(clk), .rst_n(rst_n), .d_async(hold_mode), .q_sync(le_s)
  );

  bdrv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cap (
    .clk(clk), .rst_n(rst_n), .d_async(cap_clk), .q_sync(cap_s)
  );

  bdrv_rise_det u_rise (
    .clk(clk), .rst_n(rst_n), .level(cap_s), .rise(cap_rise)
  );

  assign mode = le_s ? MODE_HOLD : MODE_FLOW;
  assign take = take_word(mode, cap_rise);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      bdrv_store_bit u_cell (
        .clk(clk), .rst_n(rst_n), .take(take), .d(a_in[b]), .q(y_data[b])
      );
    end
  endgenerate

  bdrv_drive #(.W(W)) u_drive (
    .clk(clk), .rst_n(rst_n), .dis_level(dis_s), .en(y_en)
  );
endmodule

module bdrv_core_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic         out_dis,
  input logic [W-1:0] y_data,
  input logic [W-1:0] y_en,
  input logic         le_s,
  input logic         cap_rise
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1 / R9: the enable follows the disable input three edges late
  a_r1_disable_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (y_en == {W{~$past(out_dis, 3)}}));

  // R2: flow mode loads the input word
  a_r2_flow_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> (y_data == $past(a_in)));

  // R3: capture edge in hold mode loads the input word
  a_r3_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && cap_rise) |=> (y_data == $past(a_in)));

  // R4: hold mode without capture edge keeps the word
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && !cap_rise) |=> $stable(y_data));

  // R8: one shared enable across all bits
  a_r8_uniform_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (y_en == '0) || (y_en == '1));
endmodule

bind bdrv_core bdrv_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .out_dis(out_dis),
  .y_data(y_data), .y_en(y_en), .le_s(le_s), .cap_rise(cap_rise)
);

// File: tb/tb_bdrv_core.sv
module tb_bdrv_core;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic         out_dis = 1'b1;
  logic         hold_mode = 1'b0;
  logic         cap_clk = 1'b0;
  logic [W-1:0] y_data;
  logic [W-1:0] y_en;

  int total = 0;
  int bad = 0;

  logic [W-1:0] m_store = '0;
  logic         m_le = 1'b0;
  logic         m_cc = 1'b0;

  bdrv_core #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .out_dis(out_dis),
    .hold_mode(hold_mode), .cap_clk(cap_clk), .y_data(y_data), .y_en(y_en)
  );

  always #5 clk = ~clk;

  initial begin
    #1000000;
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog: run did not complete, got hung expected done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // The bench's own statement of the function table.
  function automatic logic [W-1:0] ref_word(input logic [W-1:0] old_w,
                                            input logic old_le, input logic old_cc,
                                            input logic new_le, input logic new_cc,
                                            input logic [W-1:0] a);
    logic loads;
    loads = !new_le || !old_le || (new_cc && !old_cc);
    return loads ? a : old_w;
  endfunction

  function automatic logic [W-1:0] ref_en(input logic dis);
    return dis ? {W{1'b0}} : {W{1'b1}};
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Apply one input set at a falling edge, let it settle, then compare.
  task automatic step(input string tag, input logic [W-1:0] a, input logic le,
                      input logic cc, input logic dis);
    @(negedge clk);
    a_in = a; hold_mode = le; cap_clk = cc; out_dis = dis;
    m_store = ref_word(m_store, m_le, m_cc, le, cc, a);
    m_le = le; m_cc = cc;
    repeat (4) @(negedge clk);
    chk({tag, " data"}, y_data, m_store);
    chk({tag, " en"}, y_en, ref_en(dis));
  endtask

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 reset data", y_data, '0);
    chk("R7 reset en", y_en, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 stays off while out_dis high", y_en, '0);

    // R1: disabled bus while data flows internally
    step("R1 disabled flow", 16'hA5A5, 1'b0, 1'b0, 1'b1);
    step("R1 disabled capture", 16'h1234, 1'b1, 1'b1, 1'b1);

    // R6: re-enable shows the retained word
    step("R6 re-enable keeps word", 16'hFFFF, 1'b1, 1'b1, 1'b0);
    chk("R6 retained value", y_data, 16'h1234);

    // R2: flow mode
    step("R2 flow a", 16'h0F0F, 1'b0, 1'b0, 1'b0);
    step("R2 flow b", 16'hF00F, 1'b0, 1'b1, 1'b0);

    // R5: mode rises, last flow word held
    step("R5 mode rise", 16'hF00F, 1'b1, 1'b1, 1'b0);
    step("R5 hold after rise", 16'h5555, 1'b1, 1'b1, 1'b0);
    chk("R5 held flow word", y_data, 16'hF00F);

    // R4: falling strobe ignored, steady strobe ignored
    step("R4 fall ignored", 16'h6666, 1'b1, 1'b0, 1'b0);
    chk("R4 word unchanged", y_data, 16'hF00F);
    // R3: capture edges, back to back
    step("R3 capture 1", 16'h7777, 1'b1, 1'b1, 1'b0);
    step("R3 low", 16'h8888, 1'b1, 1'b0, 1'b0);
    step("R3 capture 2", 16'h9999, 1'b1, 1'b1, 1'b0);
    chk("R3 second capture", y_data, 16'h9999);

    // R9: latency checks from a settled hold state
    @(negedge clk);
    a_in = 16'hC3C3; cap_clk = 1'b0;
    repeat (4) @(negedge clk);
    cap_clk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 capture not before third edge", y_data, 16'h9999);
    @(negedge clk);
    chk("R9 capture at third edge", y_data, 16'hC3C3);
    out_dis = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 disable not before third edge", y_en, '1);
    @(negedge clk);
    chk("R9 disable at third edge", y_en, '0);
    hold_mode = 1'b0;
    repeat (4) @(negedge clk);
    a_in = 16'h3C3C;
    #1;
    chk("R9 flow data before edge", y_data, 16'hC3C3);
    @(negedge clk);
    chk("R9 flow data after one edge", y_data, 16'h3C3C);
    m_store = 16'h3C3C; m_le = 1'b0; m_cc = 1'b1;
    out_dis = 1'b0;
    repeat (4) @(negedge clk);

    // R8 and random mix
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a;
      logic le, cc, dis;
      a   = W'($urandom);
      le  = ($urandom % 4) != 0 ? m_le : ~m_le;
      cc  = ($urandom % 2) == 0 ? m_cc : ~m_cc;
      dis = ($urandom % 5) == 0;
      step("R8 random", a, le, cc, dis);
    end
    held = m_store;
    chk("R8 final word", y_data, held);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule